// File: doc/BRIEF.md
# Dual-Rail HDB3/AMI Line Decoder

This block sits behind the slicer of a line receiver. It turns the recovered positive and negative pulse rails into one NRZ data stream. Both rails are sampled on the recovered clock. Each sampled pair forms a slot symbol: no pulse, positive, negative, or both rails at once. The symbols pass through a four-slot delay line. While a symbol is in that line, a polarity tracker can still mark the slot as the last part of an HDB3 zero substitution. A marked slot decodes as zeros, and any slot may carry a bipolar-violation mark. The `hdb3_en` input selects HDB3 or AMI decoding, and that choice is shared by every lane built from this block.

A mode detector runs on the same clock and watches the transmit negative-rail input `tx_neg`. While that input stays high for more than `HOLD_CYCLES` consecutive samples, the receive outputs carry the decoded data and the violation flag. Otherwise they carry the two raw rails, delayed by the same pipeline. The `launch_on_fall` input moves the output update from the rising edge to the following falling edge, so that a downstream device can sample on either edge. A separate slicer mode (`rz_mode`) bypasses the pipeline: the rails go straight to the outputs, and their exclusive-OR is given as a derived clock for external clock recovery.

Three state machines make up the block.
- Mode detector: states MD_BIPOLAR, MD_COUNT and MD_UNIPOLAR.
  - MD_BIPOLAR moves to MD_COUNT on a high sample.
  - MD_COUNT counts high samples. It moves to MD_UNIPOLAR on the high sample after the count has reached `HOLD_CYCLES`.
  - Any low sample returns the detector to MD_BIPOLAR from either of the other states.
- Polarity tracker: states TRK_IDLE, TRK_POS and TRK_NEG.
  - TRK_IDLE means no pulse has been seen since reset.
  - A positive or negative symbol moves the tracker to TRK_POS or TRK_NEG.
  - An empty symbol or a both-rails symbol leaves the state unchanged.
- Output launch: the rise stage and the fall stage, chosen by `launch_on_fall`.

Top module: `dualrail_line_decoder`

## Requirements
- R1: While `rst_n` is low, `rpos_out`, `rneg_out` and `rz_clk` are 0 (with `rz_mode` low). The detector starts in MD_BIPOLAR and the tracker starts in TRK_IDLE.
- R2: In bipolar mode, a rail pair sampled at rising edge n appears unchanged on `rpos_out`/`rneg_out` after rising edge n+4. No substitution removal and no flagging take place in this mode.
- R3: The outputs switch to unipolar only after `tx_neg` has been sampled high on `HOLD_CYCLES`+1 consecutive rising edges (17 by default). After 16 such edges the block is still in bipolar mode.
- R4: A single low sample of `tx_neg` returns the block to bipolar mode at that edge and restarts the count.
- R5: In unipolar AMI mode (`hdb3_en`=0), every pulse decodes as 1 on `rpos_out`. A pulse with the same polarity as the previous pulse raises `rneg_out` for exactly one cycle, aligned with that pulse's data, with latency 4.
- R6: In unipolar HDB3 mode, a pulse of the same polarity as the previous pulse that follows three empty slots (000V) decodes as four zeros and is not flagged.
- R7: In unipolar HDB3 mode, a same-polarity pulse whose three preceding slots are a pulse then two empty slots (B00V) decodes as four zeros and is not flagged.
- R8: In unipolar HDB3 mode, a same-polarity pulse that matches neither window is flagged and decodes as 1.
- R9: A slot with both rails high is flagged and decodes as 1 in either decoding mode.
- R10: The first pulse after reset is never flagged and never taken as a substitution; it decodes as 1.
- R11: With `launch_on_fall`=1, the outputs change at the falling edge that follows the rising edge at which they would otherwise change.
- R12: With `rz_mode`=1, `rpos_out`=`rpos_in`, `rneg_out`=`rneg_in` and `rz_clk`=`rpos_in` XOR `rneg_in`, combinationally. With `rz_mode`=0, `rz_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock; also samples `tx_neg` |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpos_in | input | 1 | Positive pulse rail from the slicer |
| rneg_in | input | 1 | Negative pulse rail from the slicer |
| tx_neg | input | 1 | Transmit negative rail, watched for a long high level |
| hdb3_en | input | 1 | 1 selects HDB3, 0 selects AMI decoding |
| rz_mode | input | 1 | 1 bypasses decoding and outputs the raw sliced rails |
| launch_on_fall | input | 1 | 1 updates the outputs on the falling clock edge |
| rpos_out | output | 1 | Positive rail (bipolar) or decoded data (unipolar) |
| rneg_out | output | 1 | Negative rail (bipolar) or violation flag (unipolar) |
| rz_clk | output | 1 | Exclusive-OR of the rails in slicer mode, else 0 |

## Verification
The bench builds the block with its default `HOLD_CYCLES` of 16. At that value the exact boundary between 16 and 17 high samples costs only a few dozen cycles, so the bench can drive it on both sides, both on first entry and again after one low sample restarts the count. Because the substitution windows are fixed at four slots, a short directed stream can cover 000V, B00V, a non-matching repeat and a both-rails slot. The first pulse after reset follows empty slots, so it also tests that the idle tracker does not mistake it for a substitution.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    localparam int SLOTS = 4;

    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_POS  = 2'd1,
        SYM_NEG  = 2'd2,
        SYM_BOTH = 2'd3
    } sym_e;

    typedef enum logic [1:0] {
        MD_BIPOLAR  = 2'd0,
        MD_COUNT    = 2'd1,
        MD_UNIPOLAR = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_POS  = 2'd1,
        TRK_NEG  = 2'd2
    } trk_e;

    typedef struct packed {
        sym_e sym;
        logic kill;
        logic viol;
    } slot_t;

    localparam int OUT_W = 4;

endpackage

// File: rtl/lrx_mode_detect.sv
module lrx_mode_detect
    import lrx_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_neg,
    output logic unipolar
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 2);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYCLES);

    mode_e            state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MD_BIPOLAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            MD_BIPOLAR: begin
                if (tx_neg) begin
                    state_d = MD_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            MD_COUNT: begin
                if (!tx_neg) begin
                    state_d = MD_BIPOLAR;
                    cnt_d   = '0;
                end else if (cnt_q >= HOLD_V) begin
                    state_d = MD_UNIPOLAR;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            MD_UNIPOLAR: begin
                if (!tx_neg) begin
                    state_d = MD_BIPOLAR;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = MD_BIPOLAR;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        unipolar = (state_q == MD_UNIPOLAR);
    end

endmodule

// File: rtl/lrx_decode_core.sv
module lrx_decode_core
    import lrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rpos_in,
    input  logic rneg_in,
    input  logic hdb3_en,
    output logic raw_pos,
    output logic raw_neg,
    output logic dec_data,
    output logic dec_flag
);
    slot_t [SLOTS-1:0] line_q, line_d;
    trk_e              trk_q, trk_d;

    sym_e in_sym;
    logic same_pol, win_zero, win_b00, subst, viol_new;
    slot_t oldest;

    always_comb begin
        in_sym   = sym_e'({rneg_in, rpos_in});
        same_pol = ((in_sym == SYM_POS) && (trk_q == TRK_POS)) ||
                   ((in_sym == SYM_NEG) && (trk_q == TRK_NEG));
        win_zero = (line_q[0].sym == SYM_NONE) && (line_q[1].sym == SYM_NONE) &&
                   (line_q[2].sym == SYM_NONE);
        win_b00  = (line_q[0].sym == SYM_NONE) && (line_q[1].sym == SYM_NONE) &&
                   (line_q[2].sym != SYM_NONE);
        subst    = hdb3_en && same_pol && (win_zero || win_b00);
        viol_new = (in_sym == SYM_BOTH) || (same_pol && !subst);
    end

    // polarity tracker
    always_comb begin
        trk_d = trk_q;
        unique case (trk_q)
            TRK_IDLE: begin
                if (in_sym == SYM_POS)      trk_d = TRK_POS;
                else if (in_sym == SYM_NEG) trk_d = TRK_NEG;
            end
            TRK_POS: begin
                if (in_sym == SYM_NEG) trk_d = TRK_NEG;
            end
            TRK_NEG: begin
                if (in_sym == SYM_POS) trk_d = TRK_POS;
            end
            default: trk_d = TRK_IDLE;
        endcase
    end

    // delay line: newest in slot 0, substitution marks the whole window
    always_comb begin
        line_d[0].sym  = in_sym;
        line_d[0].kill = subst;
        line_d[0].viol = viol_new;
    end

    for (genvar i = 1; i < SLOTS; i++) begin : g_shift
        always_comb begin
            line_d[i]      = line_q[i-1];
            line_d[i].kill = line_q[i-1].kill | subst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            trk_q  <= TRK_IDLE;
        end else begin
            line_q <= line_d;
            trk_q  <= trk_d;
        end
    end

    always_comb begin
        oldest   = line_q[SLOTS-1];
        raw_pos  = oldest.sym[0];
        raw_neg  = oldest.sym[1];
        dec_data = (oldest.sym != SYM_NONE) && !oldest.kill;
        dec_flag = oldest.viol && !oldest.kill;
    end

endmodule

// File: rtl/lrx_out_stage.sv
module lrx_out_stage
    import lrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_on_fall,
    input  logic [OUT_W-1:0] d_in,
    output logic [OUT_W-1:0] q_out
);
    logic [OUT_W-1:0] rise_q, fall_q;

    for (genvar b = 0; b < OUT_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rise_q[b] <= 1'b0;
            else        rise_q[b] <= d_in[b];
        end
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fall_q[b] <= 1'b0;
            else        fall_q[b] <= rise_q[b];
        end
    end

    always_comb begin
        q_out = launch_on_fall ? fall_q : rise_q;
    end

endmodule

// File: rtl/dualrail_line_decoder.sv
module dualrail_line_decoder
    import lrx_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rpos_in,
    input  logic rneg_in,
    input  logic tx_neg,
    input  logic hdb3_en,
    input  logic rz_mode,
    input  logic launch_on_fall,
    output logic rpos_out,
    output logic rneg_out,
    output logic rz_clk
);
    logic uni_mode;
    logic raw_pos, raw_neg, dec_data, dec_flag;
    logic [OUT_W-1:0] stage_in, stage_out;

    lrx_mode_detect #(.HOLD_CYCLES(HOLD_CYCLES)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_neg   (tx_neg),
        .unipolar (uni_mode)
    );

    lrx_decode_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rpos_in  (rpos_in),
        .rneg_in  (rneg_in),
        .hdb3_en  (hdb3_en),
        .raw_pos  (raw_pos),
        .raw_neg  (raw_neg),
        .dec_data (dec_data),
        .dec_flag (dec_flag)
    );

    always_comb begin
        stage_in = {dec_flag, dec_data, raw_neg, raw_pos};
    end

    lrx_out_stage u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch_on_fall (launch_on_fall),
        .d_in           (stage_in),
        .q_out          (stage_out)
    );

    always_comb begin
        if (rz_mode) begin
            rpos_out = rpos_in;
            rneg_out = rneg_in;
            rz_clk   = rpos_in ^ rneg_in;
        end else if (uni_mode) begin
            rpos_out = stage_out[2];
            rneg_out = stage_out[3];
            rz_clk   = 1'b0;
        end else begin
            rpos_out = stage_out[0];
            rneg_out = stage_out[1];
            rz_clk   = 1'b0;
        end
    end

endmodule

// File: rtl/dualrail_line_decoder_chk.sv
module dualrail_line_decoder_chk #(
    parameter int HOLD_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tx_neg,
    input logic unipolar,
    input logic rz_mode,
    input logic rpos_in,
    input logic rneg_in,
    input logic rpos_out,
    input logic rneg_out,
    input logic rz_clk
);
    localparam int RW = $clog2(HOLD_CYCLES + 3);
    localparam logic [RW-1:0] NEED = RW'(HOLD_CYCLES + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_q <= '0;
        else if (!tx_neg)     run_q <= '0;
        else if (run_q < NEED) run_q <= run_q + RW'(1);
    end

    // R4
    tx_low_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_neg |=> !unipolar);

    // R3
    uni_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unipolar) |-> $past(tx_neg));

    // R3
    uni_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unipolar |-> (run_q >= NEED));

    // R12
    rz_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rz_mode |-> (rpos_out == rpos_in) && (rneg_out == rneg_in));

    // R12
    rz_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rz_mode |-> !rz_clk);

    // R9
    flag_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unipolar && !rz_mode && rneg_out) |-> rpos_out);

endmodule

bind dualrail_line_decoder dualrail_line_decoder_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_neg   (tx_neg),
    .unipolar (uni_mode),
    .rz_mode  (rz_mode),
    .rpos_in  (rpos_in),
    .rneg_in  (rneg_in),
    .rpos_out (rpos_out),
    .rneg_out (rneg_out),
    .rz_clk   (rz_clk)
);

// File: tb/tb_dualrail_line_decoder.sv
module tb_dualrail_line_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rpos_in = 1'b0, rneg_in = 1'b0, tx_neg = 1'b0;
    logic hdb3_en = 1'b1, rz_mode = 1'b0, launch_on_fall = 1'b0;
    logic rpos_out, rneg_out, rz_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dualrail_line_decoder dut (
        .clk(clk), .rst_n(rst_n), .rpos_in(rpos_in), .rneg_in(rneg_in),
        .tx_neg(tx_neg), .hdb3_en(hdb3_en), .rz_mode(rz_mode),
        .launch_on_fall(launch_on_fall), .rpos_out(rpos_out),
        .rneg_out(rneg_out), .rz_clk(rz_clk)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic p, input logic n);
        rpos_in = p;
        rneg_in = n;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rpos_in = 0; rneg_in = 0; tx_neg = 0;
        rz_mode = 0; launch_on_fall = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic enter_unipolar();
        tx_neg = 1'b1;
        for (int i = 0; i < 17; i++) push(0, 0);
    endtask

    // symbols packed 2 bits each: bit0 positive rail, bit1 negative rail
    task automatic run_seq(input string req, input int len, input logic [31:0] syms,
                           input logic [15:0] exp_a, input logic [15:0] exp_b);
        for (int i = 0; i < len + 4; i++) begin
            if (i < len) push(syms[2*i], syms[2*i+1]);
            else         push(0, 0);
            if (i >= 4) begin
                check(req, rpos_out, exp_a[i-4]);
                check(req, rneg_out, exp_b[i-4]);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        rpos_in = 1; rneg_in = 1; tx_neg = 0; rz_mode = 0;
        #3;
        check("R1 rpos_out", rpos_out, 1'b0);
        check("R1 rneg_out", rneg_out, 1'b0);
        check("R1 rz_clk", rz_clk, 1'b0);
    endtask

    task automatic t_bipolar();
        // P N 0 B P 0 0 0 P
        do_reset();
        hdb3_en = 1;
        run_seq("R2", 9, 32'b01_00_00_00_01_11_00_10_01,
                16'b1_0_0_0_1_1_0_0_1, 16'b0_0_0_0_0_1_0_1_0);
    endtask

    task automatic t_hdb3();
        // P 0 0 0 P | N P 0 0 P | N N B 0
        do_reset();
        hdb3_en = 1;
        enter_unipolar();
        run_seq("R6/R7/R8/R9/R10", 14, 32'b00_11_10_10_01_00_00_01_10_01_00_00_00_01,
                16'b0_1_1_1_0_0_0_0_1_0_0_0_0_1,
                16'b0_1_1_0_0_0_0_0_0_0_0_0_0_0);
    endtask

    task automatic t_ami();
        // P 0 0 0 P N N P
        do_reset();
        hdb3_en = 0;
        enter_unipolar();
        run_seq("R5/R10", 8, 32'b01_10_10_01_00_00_00_01,
                16'b1_1_1_1_0_0_0_1, 16'b0_1_0_1_0_0_0_0);
    endtask

    task automatic t_both_ami();
        // R9 in AMI: N B N
        do_reset();
        hdb3_en = 0;
        enter_unipolar();
        run_seq("R9", 3, 32'b10_11_10, 16'b111, 16'b110);
    endtask

    task automatic t_mode();
        do_reset();
        hdb3_en = 0;
        tx_neg = 1;
        for (int i = 1; i <= 16; i++) push(1, 0);
        check("R3 still bipolar after 16", rneg_out, 1'b0);
        check("R3 raw rail after 16", rpos_out, 1'b1);
        push(1, 0);
        check("R3 unipolar after 17", rneg_out, 1'b1);
        tx_neg = 0;
        push(1, 0);
        check("R4 low sample exits", rneg_out, 1'b0);
        tx_neg = 1;
        for (int i = 1; i <= 16; i++) push(1, 0);
        check("R4 count restarted", rneg_out, 1'b0);
        push(1, 0);
        check("R4 re-entry after 17", rneg_out, 1'b1);
    endtask

    task automatic t_fall();
        do_reset();
        launch_on_fall = 1;
        push(1, 0);
        push(0, 0); push(0, 0); push(0, 0);
        push(0, 0);
        check("R11 no change at rising edge", rpos_out, 1'b0);
        @(negedge clk); #1;
        check("R11 change at falling edge", rpos_out, 1'b1);
        launch_on_fall = 0;
    endtask

    task automatic t_rz();
        do_reset();
        rz_mode = 1;
        for (int c = 0; c < 4; c++) begin
            rpos_in = c[0]; rneg_in = c[1];
            #1;
            check("R12 rpos pass", rpos_out, c[0]);
            check("R12 rneg pass", rneg_out, c[1]);
            check("R12 xor clock", rz_clk, c[0] ^ c[1]);
        end
        rz_mode = 0;
        rpos_in = 1; rneg_in = 0;
        #1;
        check("R12 clock idle outside rz", rz_clk, 1'b0);
        rpos_in = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bipolar();
        t_hdb3();
        t_ami();
        t_both_ami();
        t_mode();
        t_fall();
        t_rz();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule